// File: doc/BRIEF.md
# Sector ECC Code Packer and Syndrome Checker

This block guards one 512-byte data sector with a 24-bit Hamming-style code. On the write side it receives the raw 32-bit parity word produced by an external column/row parity accumulator. It drops the two reserved nibbles, joins the two 12-bit parity halves into a 24-bit code and inverts it. Because of the inversion, a sector read back fully erased (all bytes 0xFF) produces a code that matches the erased spare area. The code is handed out as three bytes, least significant byte first.

On the read side it takes the code stored with the sector and the code just computed from the data. It forms their bitwise difference and sorts the result into one of four verdicts: clean, one flipped data bit that can be repaired, one flipped bit inside the stored code itself, or damage that cannot be repaired. For a repairable flip it reports the byte offset inside the sector and a one-hot mask of the bit to toggle. Applying the fix to the data buffer is left to the caller.

The verdict lives in a small state machine with five named states. ST_IDLE is entered only by reset. ST_CLEAN, ST_FIXED, ST_ECC_ONLY and ST_FATAL each record the last verdict. On a compare strobe, every state moves to the state for the new verdict (transitions "judge"). Without a strobe, every state stays where it is (transition "hold").

Top module: `ecc_sector_guard`

## Requirements
- R1: While reset is low and in the first cycle after it, code_o, status_o, byte_ofs_o and bit_mask_o are zero, and code_vld_o and res_vld_o are low.
- R2: One cycle after pack_stb_i, code_vld_o is high for one cycle and code_o equals the bitwise inverse of {raw_par_i[27:16], raw_par_i[11:0]}; raw bits 31:28 and 15:12 have no effect on code_o.
- R3: A raw parity word whose used bits are all zero packs to 24'hFFFFFF, and a stored code of 24'hFFFFFF compared with a calculated 24'hFFFFFF gives status 00.
- R4: The code leaves as bytes in the order code_o[7:0] first, then code_o[15:8], then code_o[23:16].
- R5: One cycle after cmp_stb_i, res_vld_o is high for one cycle; the difference is calc_code_i XOR stored_code_i, and a zero difference gives status 00 with byte_ofs_o = 0 and bit_mask_o = 0.
- R6: When diff[23:12] XOR diff[11:0] equals 12'hFFF and diff[23:15] is below SECTOR_BYTES, status is 01, byte_ofs_o = diff[23:15] and bit_mask_o = 1 << diff[14:12].
- R7: When the two difference halves are complements but diff[23:15] is not below SECTOR_BYTES, status is 11.
- R8: A difference with exactly one bit set gives status 10, with byte_ofs_o = 0 and bit_mask_o = 0.
- R9: Any other nonzero difference gives status 11, with byte_ofs_o = 0 and bit_mask_o = 0.
- R10: Without a compare strobe, status_o, byte_ofs_o and bit_mask_o keep the last verdict; a pack strobe and a compare strobe in the same cycle are both served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pack_stb_i | input | 1 | Pack request for raw_par_i |
| raw_par_i | input | 32 | Raw parity word from the accumulator |
| code_o | output | 24 | Packed, inverted code; byte 0 in bits 7:0 |
| code_vld_o | output | 1 | One-cycle pulse: code_o updated |
| cmp_stb_i | input | 1 | Compare request |
| stored_code_i | input | 24 | Code read from the spare area |
| calc_code_i | input | 24 | Code computed from the data just read |
| res_vld_o | output | 1 | One-cycle pulse: verdict updated |
| status_o | output | 2 | 00 clean, 01 data bit fixed, 10 code-only error, 11 uncorrectable |
| byte_ofs_o | output | 9 | Byte offset of the flipped bit |
| bit_mask_o | output | 8 | One-hot mask of the flipped bit |

## Verification
The packer and the syndrome checker are independent paths that can both be strobed on the same clock edge. The bench asserts pack_stb_i and cmp_stb_i together with a known raw word and a repairable difference. It then checks code_o against the packing rule and the verdict, offset and mask against the correction rule in the following cycle. A second instance with a 256-byte sector shows the out-of-range offset path, which cannot be reached at the default size.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

    typedef enum logic [1:0] {
        VERD_CLEAN    = 2'b00,
        VERD_FIXED    = 2'b01,
        VERD_ECC_ONLY = 2'b10,
        VERD_FATAL    = 2'b11
    } verdict_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAN,
        ST_FIXED,
        ST_ECC_ONLY,
        ST_FATAL
    } guard_state_t;

endpackage

// File: rtl/ecc_packer.sv
module ecc_packer #(
    parameter int HALF_W = 12,
    parameter int RSV_W  = 4,
    localparam int RAW_W  = 2 * (HALF_W + RSV_W),
    localparam int CODE_W = 2 * HALF_W,
    localparam int SLOT_W = HALF_W + RSV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pack_stb,
    input  logic [RAW_W-1:0]  raw_par,
    output logic [CODE_W-1:0] code,
    output logic              code_vld
);

    logic [CODE_W-1:0] joined;
    logic              rsv_unused;

    // each half of the raw word carries HALF_W parity bits below RSV_W reserved bits
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign joined[h*HALF_W +: HALF_W] = raw_par[h*SLOT_W +: HALF_W];
    end

    assign rsv_unused = ^{raw_par[SLOT_W-1 -: RSV_W], raw_par[RAW_W-1 -: RSV_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code     <= '0;
            code_vld <= 1'b0;
        end else begin
            code_vld <= pack_stb;
            if (pack_stb) begin
                code <= ~joined;
            end
        end
    end

    // R2: a pack request is answered on the next cycle
    a_r2_code_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pack_stb |=> code_vld);

    // R3: all-zero used parity bits give an all-ones code
    a_r3_erased_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (pack_stb && raw_par[HALF_W-1:0] == '0 && raw_par[SLOT_W +: HALF_W] == '0)
        |=> (code == {CODE_W{1'b1}}));

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
    import ecc_guard_pkg::*;
#(
    parameter int HALF_W       = 12,
    parameter int MASK_W       = 8,
    parameter int SECTOR_BYTES = 512,
    localparam int CODE_W = 2 * HALF_W,
    localparam int BIT_W  = $clog2(MASK_W),
    localparam int OFS_W  = HALF_W - BIT_W
) (
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    output verdict_t          verdict,
    output logic [OFS_W-1:0]  ofs,
    output logic [MASK_W-1:0] mask
);

    localparam logic [OFS_W:0] SECT_LIM = (OFS_W + 1)'(SECTOR_BYTES);

    logic [CODE_W-1:0] diff;
    logic [HALF_W-1:0] upper;
    logic [HALF_W-1:0] lower;
    logic [BIT_W-1:0]  bit_idx;
    logic              halves_cmpl;
    logic              single_bit;
    logic              in_sector;

    assign diff        = calc_code ^ stored_code;
    assign upper       = diff[CODE_W-1 -: HALF_W];
    assign lower       = diff[HALF_W-1:0];
    assign halves_cmpl = ((upper ^ lower) == {HALF_W{1'b1}});
    assign single_bit  = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
    assign ofs         = upper[HALF_W-1 -: OFS_W];
    assign bit_idx     = upper[BIT_W-1:0];
    assign mask        = MASK_W'(1) << bit_idx;
    assign in_sector   = ({1'b0, ofs} < SECT_LIM);

    always_comb begin
        if (diff == '0) begin
            verdict = VERD_CLEAN;
        end else if (halves_cmpl) begin
            verdict = in_sector ? VERD_FIXED : VERD_FATAL;
        end else if (single_bit) begin
            verdict = VERD_ECC_ONLY;
        end else begin
            verdict = VERD_FATAL;
        end
    end

    // R7: a repair is only ever offered inside the sector
    always_comb begin
        a_r7_ofs_in_sector: assert (verdict != VERD_FIXED || ({1'b0, ofs} < SECT_LIM));
    end

endmodule

// File: rtl/ecc_verdict_fsm.sv
module ecc_verdict_fsm
    import ecc_guard_pkg::*;
#(
    parameter int OFS_W  = 9,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_stb,
    input  verdict_t          verdict,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [MASK_W-1:0] mask,
    output logic              res_vld,
    output logic [1:0]        status,
    output logic [OFS_W-1:0]  byte_ofs,
    output logic [MASK_W-1:0] bit_mask
);

    guard_state_t state;
    guard_state_t state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions: "judge" on a strobe, "hold" otherwise
    always_comb begin
        state_nxt = state;
        if (cmp_stb) begin
            unique case (verdict)
                VERD_CLEAN:    state_nxt = ST_CLEAN;
                VERD_FIXED:    state_nxt = ST_FIXED;
                VERD_ECC_ONLY: state_nxt = ST_ECC_ONLY;
                VERD_FATAL:    state_nxt = ST_FATAL;
                default:       state_nxt = ST_FATAL;
            endcase
        end
    end

    // registered locator and pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            byte_ofs <= '0;
            bit_mask <= '0;
        end else begin
            res_vld <= cmp_stb;
            if (cmp_stb) begin
                if (verdict == VERD_FIXED) begin
                    byte_ofs <= ofs;
                    bit_mask <= mask;
                end else begin
                    byte_ofs <= '0;
                    bit_mask <= '0;
                end
            end
        end
    end

    // status decode from the state
    always_comb begin
        unique case (state)
            ST_IDLE:     status = VERD_CLEAN;
            ST_CLEAN:    status = VERD_CLEAN;
            ST_FIXED:    status = VERD_FIXED;
            ST_ECC_ONLY: status = VERD_ECC_ONLY;
            ST_FATAL:    status = VERD_FATAL;
            default:     status = VERD_FATAL;
        endcase
    end

    // R5: a compare request is answered on the next cycle
    a_r5_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_stb |=> res_vld);

    // R10: without a strobe the verdict is held
    a_r10_hold_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_stb |=> ($stable(status) && $stable(byte_ofs) && $stable(bit_mask)));

    // R8, R9: locator is quiet unless a data bit was repaired
    a_r8_quiet_locator: assert property (@(posedge clk) disable iff (!rst_n)
        (status != VERD_FIXED) |-> (bit_mask == '0 && byte_ofs == '0));

    // R6: a repair names exactly one bit
    a_r6_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (status == VERD_FIXED) |-> $onehot(bit_mask));

endmodule

// File: rtl/ecc_sector_guard.sv
module ecc_sector_guard
    import ecc_guard_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pack_stb_i,
    input  logic [31:0] raw_par_i,
    output logic [23:0] code_o,
    output logic        code_vld_o,
    input  logic        cmp_stb_i,
    input  logic [23:0] stored_code_i,
    input  logic [23:0] calc_code_i,
    output logic        res_vld_o,
    output logic [1:0]  status_o,
    output logic [8:0]  byte_ofs_o,
    output logic [7:0]  bit_mask_o
);

    localparam int HALF_W = 12;
    localparam int RSV_W  = 4;
    localparam int MASK_W = 8;
    localparam int OFS_W  = HALF_W - $clog2(MASK_W);

    verdict_t          verdict;
    logic [OFS_W-1:0]  ofs;
    logic [MASK_W-1:0] mask;

    ecc_packer #(
        .HALF_W (HALF_W),
        .RSV_W  (RSV_W)
    ) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pack_stb (pack_stb_i),
        .raw_par  (raw_par_i),
        .code     (code_o),
        .code_vld (code_vld_o)
    );

    ecc_syndrome #(
        .HALF_W       (HALF_W),
        .MASK_W       (MASK_W),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_syndrome (
        .stored_code (stored_code_i),
        .calc_code   (calc_code_i),
        .verdict     (verdict),
        .ofs         (ofs),
        .mask        (mask)
    );

    ecc_verdict_fsm #(
        .OFS_W  (OFS_W),
        .MASK_W (MASK_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_stb  (cmp_stb_i),
        .verdict  (verdict),
        .ofs      (ofs),
        .mask     (mask),
        .res_vld  (res_vld_o),
        .status   (status_o),
        .byte_ofs (byte_ofs_o),
        .bit_mask (bit_mask_o)
    );

endmodule

// File: tb/tb_ecc_sector_guard.sv
module tb_ecc_sector_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [23:0] stored;
        logic [23:0] diff;
        logic [1:0]  st;
        logic [8:0]  ofs;
        logic [7:0]  msk;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{24'h123456, 24'h000000, 2'b00, 9'd0,   8'h00},
        '{24'hFFFFFF, 24'h000000, 2'b00, 9'd0,   8'h00},
        '{24'h123456, 24'h02BFD4, 2'b01, 9'd5,   8'h08},
        '{24'hABCDEF, 24'hFFF000, 2'b01, 9'd511, 8'h80},
        '{24'h000000, 24'h000FFF, 2'b01, 9'd0,   8'h01},
        '{24'h0F1E2D, 24'h8027FD, 2'b01, 9'd256, 8'h04},
        '{24'h555555, 24'h000001, 2'b10, 9'd0,   8'h00},
        '{24'h555555, 24'h800000, 2'b10, 9'd0,   8'h00},
        '{24'h0F0F0F, 24'h000003, 2'b11, 9'd0,   8'h00},
        '{24'h0F0F0F, 24'h123456, 2'b11, 9'd0,   8'h00}
    };

    localparam string TAGS [NVEC] = '{
        "R5", "R3", "R6", "R6", "R6", "R6", "R8", "R8", "R9", "R9"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pack_stb = 1'b0;
    logic [31:0] raw_par = '0;
    logic        cmp_stb = 1'b0;
    logic [23:0] stored = '0;
    logic [23:0] calc = '0;

    logic [23:0] code, code_s;
    logic        code_vld, code_vld_s;
    logic        res_vld, res_vld_s;
    logic [1:0]  status, status_s;
    logic [8:0]  byte_ofs, byte_ofs_s;
    logic [7:0]  bit_mask, bit_mask_s;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ecc_sector_guard dut (
        .clk (clk), .rst_n (rst_n),
        .pack_stb_i (pack_stb), .raw_par_i (raw_par),
        .code_o (code), .code_vld_o (code_vld),
        .cmp_stb_i (cmp_stb), .stored_code_i (stored), .calc_code_i (calc),
        .res_vld_o (res_vld), .status_o (status),
        .byte_ofs_o (byte_ofs), .bit_mask_o (bit_mask)
    );

    ecc_sector_guard #(.SECTOR_BYTES(256)) dut_small (
        .clk (clk), .rst_n (rst_n),
        .pack_stb_i (pack_stb), .raw_par_i (raw_par),
        .code_o (code_s), .code_vld_o (code_vld_s),
        .cmp_stb_i (cmp_stb), .stored_code_i (stored), .calc_code_i (calc),
        .res_vld_o (res_vld_s), .status_o (status_s),
        .byte_ofs_o (byte_ofs_s), .bit_mask_o (bit_mask_s)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive a strobe for one cycle; sample one cycle later at the falling edge
    task automatic do_pack(input logic [31:0] raw);
        @(negedge clk);
        raw_par  = raw;
        pack_stb = 1'b1;
        @(negedge clk);
        pack_stb = 1'b0;
    endtask

    task automatic do_cmp(input logic [23:0] s, input logic [23:0] d);
        @(negedge clk);
        stored  = s;
        calc    = s ^ d;
        cmp_stb = 1'b1;
        @(negedge clk);
        cmp_stb = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 code", code, 0);
        chk("R1 status", status, 0);
        chk("R1 valids", {code_vld, res_vld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {code, status, byte_ofs, bit_mask, code_vld, res_vld}, 0);

        // R2 / R3 / R4: packing
        do_pack(32'h0ABC0123);
        chk("R2 code", code, 32'h543EDC);
        chk("R2 code_vld", code_vld, 1);
        chk("R4 byte0", code[7:0], 8'hDC);
        chk("R4 byte1", code[15:8], 8'h3E);
        chk("R4 byte2", code[23:16], 8'h54);
        @(negedge clk);
        chk("R2 pulse ends", code_vld, 0);
        do_pack(32'hF000F000);
        chk("R2 reserved ignored", code, 32'hFFFFFF);
        do_pack(32'h00000000);
        chk("R3 erased code", code, 32'hFFFFFF);
        do_pack(32'hFFFFFFFF);
        chk("R2 all ones raw", code, 0);
        do_pack(32'h5A5AA5A5);
        chk("R2 mixed raw", code, 32'h5A5A5A);

        // table of compare vectors
        for (int i = 0; i < NVEC; i++) begin
            do_cmp(VECS[i].stored, VECS[i].diff);
            chk({TAGS[i], " res_vld"}, res_vld, 1);
            chk({TAGS[i], " status"}, status, VECS[i].st);
            chk({TAGS[i], " ofs"}, byte_ofs, VECS[i].ofs);
            chk({TAGS[i], " mask"}, bit_mask, VECS[i].msk);
        end

        // R10: hold without strobe after a repair verdict
        do_cmp(24'h123456, 24'h02BFD4);
        stored = 24'h000000;
        calc   = 24'h123456;
        repeat (3) @(negedge clk);
        chk("R10 pulse ends", res_vld, 0);
        chk("R10 status held", status, 2'b01);
        chk("R10 ofs held", byte_ofs, 5);
        chk("R10 mask held", bit_mask, 8'h08);

        // R10: pack and compare in the same cycle
        @(negedge clk);
        raw_par  = 32'h0ABC0123;
        stored   = 24'h123456;
        calc     = 24'h123456 ^ 24'h02BFD4;
        pack_stb = 1'b1;
        cmp_stb  = 1'b1;
        @(negedge clk);
        pack_stb = 1'b0;
        cmp_stb  = 1'b0;
        chk("R10 both code", code, 32'h543EDC);
        chk("R10 both valids", {code_vld, res_vld}, 2'b11);
        chk("R10 both status", status, 2'b01);
        chk("R10 both mask", bit_mask, 8'h08);

        // R7: offset beyond a 256-byte sector
        do_cmp(24'h0F1E2D, 24'h8027FD);
        chk("R7 small status", status_s, 2'b11);
        chk("R7 small mask", bit_mask_s, 0);
        chk("R7 large status", status, 2'b01);
        do_cmp(24'h123456, 24'h02BFD4);
        chk("R7 small in range", status_s, 2'b01);
        chk("R7 small ofs", byte_ofs_s, 5);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule